// File: doc/BRIEF.md
# Dual-Clock Inter-Processor Mailbox

This block connects two processors that sit on separate buses, each with its own clock. Each side has a small memory-mapped register port. Through it a processor posts 32-bit words to its peer, rings data-less doorbells on the peer, and reads what the peer sent. Each direction has four data channels and four doorbell channels. All traffic crosses between the two clock domains through toggle handshakes, so a multi-bit value is never sampled while it is changing.

The two sides are mirror images. A word written to transmit channel i on one side shows up in receive register i on the other side. Reading that receive register frees the channel, and the freed state travels back to the sender as its transmit-empty flag. Doorbells carry no data and produce no acknowledge for the sender. A doorbell stays pending at the receiver until that side clears it. Each side drives one level interrupt, active high. It is the OR of that side's pending flags masked by that side's enable register.

The register offsets below are fixed for the default of four channels per kind. Offsets 0 to 3 hold data: a write sends the word on that transmit channel, and a read returns that receive register. Offset 4 is status (read only). Offset 5 rings doorbells (write 1 to a bit). Offset 6 clears pending doorbells (write 1 to a bit; a read returns the pending bits). Offset 7 is the enable register.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, the status register on each side reads 0x0F0: every transmit channel empty, nothing received, nothing pending. The enable register and the data registers read 0, and both interrupts are low.
- R2: A write of word W to offset i (0..3) clears status bit 4+i of the sending side from the next cycle on. After the crossing, status bit i of the peer is set and offset i of the peer reads W.
- R3: A peer read of offset i while status bit i is set clears that bit. After the return crossing, the sender's status bit 4+i is set again. A receive flag never clears without such a read.
- R4: A write to a transmit channel whose empty bit is 0 is dropped. The peer receives the earlier word, and while the receive flag stays set the receive register holds its value.
- R5: Data channels work the same way from side B to side A as from side A to side B.
- R6: Writing 1 to bit i of offset 5 sets doorbell-pending status bit 8+i on the peer, and only on the peer. Doorbells do not touch data or transmit-empty flags.
- R7: A pending doorbell stays set until its own side writes 1 to bit i of offset 6. Ringing it again while it is pending has no effect: a single clear leaves it at 0 for good.
- R8: A side's interrupt is high exactly when some status bit is set whose matching bit in the enable register (offset 7, same bit layout as status) is also set. The interrupt follows a change of status or enable within one cycle of that side's clock.
- R9: Reading the status register does not change any flag on either side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | 1 | Side A clock |
| clk_b_i | input | 1 | Side B clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| a_sel_i | input | 1 | Side A access strobe |
| a_we_i | input | 1 | Side A write (1) or read (0) |
| a_addr_i | input | 3 | Side A register offset |
| a_wdata_i | input | 32 | Side A write data |
| a_rdata_o | output | 32 | Side A read data, combinational on the address |
| a_irq_o | output | 1 | Side A level interrupt |
| b_sel_i | input | 1 | Side B access strobe |
| b_we_i | input | 1 | Side B write (1) or read (0) |
| b_addr_i | input | 3 | Side B register offset |
| b_wdata_i | input | 32 | Side B write data |
| b_rdata_o | output | 32 | Side B read data, combinational on the address |
| b_irq_o | output | 1 | Side B level interrupt |

## Verification
A handshake toggle stuck on one side, or a wrong toggle, shows up within a few cycles of the slower clock. It appears either as a receive flag that never rises at the peer, or as a transmit-empty flag that never comes back at the sender. The bench therefore reads both status registers after every crossing. A hold register that takes a second write while busy delivers the wrong word, and the very next peer data read exposes it. A wrong mask or status bit ordering drives the wrong interrupt level one cycle after the enable write.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  parameter int MBX_NCH = 4;
  parameter int MBX_DW  = 32;
  // control offsets above the data window
  localparam int MBX_OFS_STAT = 0;
  localparam int MBX_OFS_RING = 1;
  localparam int MBX_OFS_CLR  = 2;
  localparam int MBX_OFS_EN   = 3;
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/mbx_link.sv
// One unidirectional channel: toggle request sender->receiver, toggle ack back.
module mbx_link #(
  parameter int DW       = 32,
  parameter bit HAS_DATA = 1'b1
) (
  input  logic          clk_s_i,
  input  logic          clk_r_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  output logic          idle_o,
  input  logic          pop_i,
  output logic          full_o,
  output logic [DW-1:0] data_o
);
  logic req_q, ack_q, ack_s, req_r, req_seen_q;
  logic take;

  mbx_sync u_req_sync (.clk_i(clk_r_i), .rst_ni(rst_ni), .d_i(req_q), .q_o(req_r));
  mbx_sync u_ack_sync (.clk_i(clk_s_i), .rst_ni(rst_ni), .d_i(ack_q), .q_o(ack_s));

  assign idle_o = (req_q == ack_s);
  assign take   = push_i && idle_o;

  always_ff @(posedge clk_s_i or negedge rst_ni) begin
    if (!rst_ni)   req_q <= 1'b0;
    else if (take) req_q <= ~req_q;
  end

  assign full_o = (req_seen_q != ack_q);

  always_ff @(posedge clk_r_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_seen_q <= 1'b0;
      ack_q      <= 1'b0;
    end else begin
      req_seen_q <= req_r;
      if (pop_i && full_o) ack_q <= ~ack_q;
    end
  end

  generate
    if (HAS_DATA) begin : g_data
      logic [DW-1:0] hold_q, cap_q;
      always_ff @(posedge clk_s_i or negedge rst_ni) begin
        if (!rst_ni)   hold_q <= '0;
        else if (take) hold_q <= data_i;
      end
      // hold_q is stable from the request toggle until the ack returns
      always_ff @(posedge clk_r_i or negedge rst_ni) begin
        if (!rst_ni)                  cap_q <= '0;
        else if (req_r != req_seen_q) cap_q <= hold_q;
      end
      assign data_o = cap_q;
    end else begin : g_bell
      logic unused_data;
      assign unused_data = ^data_i;
      assign data_o = '0;
    end
  endgenerate
endmodule

// File: rtl/mbx_side_regs.sv
module mbx_side_regs import mbx_pkg::*; #(
  parameter int NCH = MBX_NCH,
  parameter int DW  = MBX_DW,
  localparam int CW = $clog2(NCH),
  localparam int AW = CW + 1,
  localparam int SW = 3 * NCH
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sel_i,
  input  logic                    we_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [DW-1:0]           wdata_i,
  output logic [DW-1:0]           rdata_o,
  output logic                    irq_o,
  output logic [NCH-1:0]          tx_push_o,
  input  logic [NCH-1:0]          tx_idle_i,
  input  logic [NCH-1:0]          rx_full_i,
  input  logic [NCH-1:0][DW-1:0]  rx_data_i,
  output logic [NCH-1:0]          rx_pop_o,
  output logic [NCH-1:0]          ring_o,
  output logic [NCH-1:0]          clr_o,
  input  logic [NCH-1:0]          pend_i
);
  localparam logic [AW-1:0] A_STAT = AW'(NCH + MBX_OFS_STAT);
  localparam logic [AW-1:0] A_RING = AW'(NCH + MBX_OFS_RING);
  localparam logic [AW-1:0] A_CLR  = AW'(NCH + MBX_OFS_CLR);
  localparam logic [AW-1:0] A_EN   = AW'(NCH + MBX_OFS_EN);

  logic          wr, rd;
  logic [SW-1:0] stat, en_q;
  logic          irq_q;

  assign wr   = sel_i && we_i;
  assign rd   = sel_i && !we_i;
  assign stat = {pend_i, tx_idle_i, rx_full_i};

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign tx_push_o[i] = wr && (addr_i == AW'(i));
    assign rx_pop_o[i]  = rd && (addr_i == AW'(i));
  end

  assign ring_o = (wr && addr_i == A_RING) ? wdata_i[NCH-1:0] : '0;
  assign clr_o  = (wr && addr_i == A_CLR)  ? wdata_i[NCH-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      if (wr && addr_i == A_EN) en_q <= wdata_i[SW-1:0];
      irq_q <= |(stat & en_q);
    end
  end
  assign irq_o = irq_q;

  always_comb begin
    rdata_o = '0;
    if (!addr_i[AW-1])        rdata_o = rx_data_i[addr_i[CW-1:0]];
    else if (addr_i == A_STAT) rdata_o = DW'(stat);
    else if (addr_i == A_CLR)  rdata_o = DW'(pend_i);
    else if (addr_i == A_EN)   rdata_o = DW'(en_q);
  end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox import mbx_pkg::*; #(
  parameter int NCH = MBX_NCH,
  parameter int DW  = MBX_DW,
  localparam int AW = $clog2(NCH) + 1
) (
  input  logic          clk_a_i,
  input  logic          clk_b_i,
  input  logic          rst_ni,
  input  logic          a_sel_i,
  input  logic          a_we_i,
  input  logic [AW-1:0] a_addr_i,
  input  logic [DW-1:0] a_wdata_i,
  output logic [DW-1:0] a_rdata_o,
  output logic          a_irq_o,
  input  logic          b_sel_i,
  input  logic          b_we_i,
  input  logic [AW-1:0] b_addr_i,
  input  logic [DW-1:0] b_wdata_i,
  output logic [DW-1:0] b_rdata_o,
  output logic          b_irq_o
);
  logic [NCH-1:0]         a_push, a_idle, a_full, a_pop, a_ring, a_pend, a_clr;
  logic [NCH-1:0]         b_push, b_idle, b_full, b_pop, b_ring, b_pend, b_clr;
  logic [NCH-1:0][DW-1:0] a_data, b_data;
  logic [NCH-1:0]         bell_ab_idle_unused, bell_ba_idle_unused;
  logic [NCH-1:0]         bell_ab_dat_unused, bell_ba_dat_unused;

  mbx_side_regs #(.NCH(NCH), .DW(DW)) u_side_a (
    .clk_i(clk_a_i), .rst_ni(rst_ni), .sel_i(a_sel_i), .we_i(a_we_i),
    .addr_i(a_addr_i), .wdata_i(a_wdata_i), .rdata_o(a_rdata_o), .irq_o(a_irq_o),
    .tx_push_o(a_push), .tx_idle_i(a_idle), .rx_full_i(a_full), .rx_data_i(a_data),
    .rx_pop_o(a_pop), .ring_o(a_ring), .clr_o(a_clr), .pend_i(a_pend));

  mbx_side_regs #(.NCH(NCH), .DW(DW)) u_side_b (
    .clk_i(clk_b_i), .rst_ni(rst_ni), .sel_i(b_sel_i), .we_i(b_we_i),
    .addr_i(b_addr_i), .wdata_i(b_wdata_i), .rdata_o(b_rdata_o), .irq_o(b_irq_o),
    .tx_push_o(b_push), .tx_idle_i(b_idle), .rx_full_i(b_full), .rx_data_i(b_data),
    .rx_pop_o(b_pop), .ring_o(b_ring), .clr_o(b_clr), .pend_i(b_pend));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    mbx_link #(.DW(DW), .HAS_DATA(1'b1)) u_dat_ab (
      .clk_s_i(clk_a_i), .clk_r_i(clk_b_i), .rst_ni(rst_ni),
      .push_i(a_push[i]), .data_i(a_wdata_i), .idle_o(a_idle[i]),
      .pop_i(b_pop[i]), .full_o(b_full[i]), .data_o(b_data[i]));
    mbx_link #(.DW(DW), .HAS_DATA(1'b1)) u_dat_ba (
      .clk_s_i(clk_b_i), .clk_r_i(clk_a_i), .rst_ni(rst_ni),
      .push_i(b_push[i]), .data_i(b_wdata_i), .idle_o(b_idle[i]),
      .pop_i(a_pop[i]), .full_o(a_full[i]), .data_o(a_data[i]));
    mbx_link #(.DW(1), .HAS_DATA(1'b0)) u_bell_ab (
      .clk_s_i(clk_a_i), .clk_r_i(clk_b_i), .rst_ni(rst_ni),
      .push_i(a_ring[i]), .data_i(1'b0), .idle_o(bell_ab_idle_unused[i]),
      .pop_i(b_clr[i]), .full_o(b_pend[i]), .data_o(bell_ab_dat_unused[i]));
    mbx_link #(.DW(1), .HAS_DATA(1'b0)) u_bell_ba (
      .clk_s_i(clk_b_i), .clk_r_i(clk_a_i), .rst_ni(rst_ni),
      .push_i(b_ring[i]), .data_i(1'b0), .idle_o(bell_ba_idle_unused[i]),
      .pop_i(a_clr[i]), .full_o(a_pend[i]), .data_o(bell_ba_dat_unused[i]));
  end
endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk #(
  parameter int NCH = 4,
  parameter int DW  = 32
) (
  input logic                   clk_a_i,
  input logic                   clk_b_i,
  input logic                   rst_ni,
  input logic [NCH-1:0]         a_push,
  input logic [NCH-1:0]         a_idle,
  input logic [NCH-1:0]         b_full,
  input logic [NCH-1:0]         b_pop,
  input logic [NCH-1:0][DW-1:0] b_data,
  input logic [NCH-1:0]         b_pend,
  input logic [NCH-1:0]         b_clr
);
  // R2
  empty_fall_chk: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    ((~a_idle & $past(a_idle)) & ~$past(a_push)) == '0);
  // R3
  full_fall_chk: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    ((~b_full & $past(b_full)) & ~$past(b_pop)) == '0);
  // R4
  rx_hold_chk: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    (b_full[0] && $past(b_full[0])) |-> $stable(b_data[0]));
  // R7
  pend_fall_chk: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    ((~b_pend & $past(b_pend)) & ~$past(b_clr)) == '0);
endmodule

bind ipc_mailbox ipc_mailbox_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk_a_i(clk_a_i), .clk_b_i(clk_b_i), .rst_ni(rst_ni),
  .a_push(a_push), .a_idle(a_idle), .b_full(b_full), .b_pop(b_pop),
  .b_data(b_data), .b_pend(b_pend), .b_clr(b_clr));

// File: tb/ipc_mailbox_tb_top.sv
`timescale 1ns/1ps
module ipc_mailbox_tb_top;
  logic clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b0;
  logic a_sel = 0, a_we = 0, b_sel = 0, b_we = 0;
  logic [2:0] a_addr = '0, b_addr = '0;
  logic [31:0] a_wdata = '0, b_wdata = '0, a_rdata, b_rdata;
  logic a_irq, b_irq;
  int checks = 0, errors = 0;

  always #2 clk_a = ~clk_a;
  always #3.5 clk_b = ~clk_b;

  ipc_mailbox dut_i (
    .clk_a_i(clk_a), .clk_b_i(clk_b), .rst_ni(rst_n),
    .a_sel_i(a_sel), .a_we_i(a_we), .a_addr_i(a_addr), .a_wdata_i(a_wdata),
    .a_rdata_o(a_rdata), .a_irq_o(a_irq),
    .b_sel_i(b_sel), .b_we_i(b_we), .b_addr_i(b_addr), .b_wdata_i(b_wdata),
    .b_rdata_o(b_rdata), .b_irq_o(b_irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // side 0 = A, 1 = B
  task automatic bus(input bit side, input bit we, input logic [2:0] addr,
                     input logic [31:0] wd, output logic [31:0] rd);
    if (!side) begin
      @(negedge clk_a); a_sel = 1; a_we = we; a_addr = addr; a_wdata = wd;
      #1 rd = a_rdata;
      @(negedge clk_a); a_sel = 0; a_we = 0;
    end else begin
      @(negedge clk_b); b_sel = 1; b_we = we; b_addr = addr; b_wdata = wd;
      #1 rd = b_rdata;
      @(negedge clk_b); b_sel = 0; b_we = 0;
    end
  endtask

  task automatic wr(input bit side, input logic [2:0] addr, input logic [31:0] wd);
    logic [31:0] d;
    bus(side, 1'b1, addr, wd, d);
  endtask

  task automatic rd_chk(input bit side, input logic [2:0] addr, input logic [31:0] exp,
                        input string req);
    logic [31:0] d;
    bus(side, 1'b0, addr, '0, d);
    chk(req, d, exp);
  endtask

  task automatic settle();
    repeat (10) @(posedge clk_b);
    @(negedge clk_a);
  endtask

  task automatic t_reset();
    rd_chk(0, 3'd4, 32'h0F0, "R1 A status");
    rd_chk(1, 3'd4, 32'h0F0, "R1 B status");
    rd_chk(0, 3'd7, 32'h0, "R1 A enable");
    rd_chk(1, 3'd0, 32'h0, "R1 B data0");
    chk("R1 A irq", {31'b0, a_irq}, 32'h0);
    chk("R1 B irq", {31'b0, b_irq}, 32'h0);
  endtask

  task automatic t_a_to_b();
    wr(0, 3'd2, 32'hDEADBEEF);
    rd_chk(0, 3'd4, 32'h0B0, "R2 A empty bit cleared");
    settle();
    rd_chk(1, 3'd4, 32'h0F4, "R2 B full bit set");
    rd_chk(1, 3'd2, 32'hDEADBEEF, "R2 B data");
    settle();
    rd_chk(1, 3'd4, 32'h0F0, "R3 B full cleared");
    rd_chk(0, 3'd4, 32'h0F0, "R3 A empty restored");
  endtask

  task automatic t_overwrite();
    wr(0, 3'd0, 32'h11111111);
    wr(0, 3'd0, 32'h22222222);
    settle();
    rd_chk(1, 3'd0, 32'h11111111, "R4 busy write dropped");
    settle();
    rd_chk(1, 3'd4, 32'h0F0, "R4 no second delivery");
  endtask

  task automatic t_b_to_a();
    wr(1, 3'd3, 32'hCAFEF00D);
    settle();
    rd_chk(0, 3'd4, 32'h0F8, "R5 A full bit set");
    rd_chk(1, 3'd4, 32'h070, "R5 B empty bit cleared");
    rd_chk(0, 3'd3, 32'hCAFEF00D, "R5 A data");
    settle();
    rd_chk(1, 3'd4, 32'h0F0, "R5 B empty restored");
  endtask

  task automatic t_stat_pure();
    wr(1, 3'd1, 32'h00000005);
    settle();
    for (int k = 0; k < 3; k++) rd_chk(0, 3'd4, 32'h0F2, "R9 A status repeat");
    settle();
    rd_chk(1, 3'd4, 32'h0D0, "R9 B still busy");
    rd_chk(0, 3'd1, 32'h00000005, "R9 data intact");
    settle();
  endtask

  task automatic t_bell();
    wr(0, 3'd5, 32'h5);
    settle();
    rd_chk(1, 3'd4, 32'h5F0, "R6 B pending set");
    rd_chk(0, 3'd4, 32'h0F0, "R6 A unaffected");
    rd_chk(1, 3'd6, 32'h5, "R6 B pending read");
    wr(0, 3'd5, 32'h1);
    settle();
    wr(1, 3'd6, 32'h1);
    settle();
    rd_chk(1, 3'd4, 32'h4F0, "R7 re-ring while pending ignored");
    settle();
    rd_chk(1, 3'd4, 32'h4F0, "R7 stays cleared");
    wr(1, 3'd6, 32'h4);
    settle();
    rd_chk(1, 3'd4, 32'h0F0, "R7 all cleared");
  endtask

  task automatic t_irq();
    wr(1, 3'd7, 32'h001);
    wr(0, 3'd5, 32'h2);
    settle();
    chk("R8 masked doorbell", {31'b0, b_irq}, 32'h0);
    wr(1, 3'd7, 32'h201);
    settle();
    chk("R8 enabled doorbell", {31'b0, b_irq}, 32'h1);
    wr(1, 3'd6, 32'h2);
    settle();
    chk("R8 doorbell cleared", {31'b0, b_irq}, 32'h0);
    wr(0, 3'd0, 32'h77);
    settle();
    chk("R8 rx full irq", {31'b0, b_irq}, 32'h1);
    rd_chk(1, 3'd0, 32'h77, "R8 data");
    settle();
    chk("R8 rx read drops irq", {31'b0, b_irq}, 32'h0);
    wr(0, 3'd7, 32'h0F0);
    settle();
    chk("R8 tx empty irq", {31'b0, a_irq}, 32'h1);
    rd_chk(0, 3'd7, 32'h0F0, "R8 enable readback");
    wr(0, 3'd7, 32'h0);
    settle();
    chk("R8 disabled", {31'b0, a_irq}, 32'h0);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_a);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk_b);
    rst_n = 1'b1;
    repeat (2) @(negedge clk_b);
    t_reset();
    t_a_to_b();
    t_overwrite();
    t_b_to_a();
    t_stat_pure();
    t_bell();
    t_irq();
    finish_run();
  end
endmodule